// File: doc/BRIEF.md
# Per-Axis Threshold Wake-Up Interrupt

This block watches a three-axis stream of signed 16-bit samples and compares every axis against one programmable 16-bit threshold. The comparison happens only in a cycle where the sample-valid strobe is high. Each axis has its own enable for the above-threshold condition and its own enable for the below-threshold condition. Any enabled condition that holds sets a flag in a source register. The interrupt request is the OR of those flags.

A latch bit picks one of two modes. In the first, the flags follow the most recent sample. In the second, the flags are held and accumulate until software reads a dedicated acknowledge address. A routing bit picks what drives the shared output pin: the interrupt request, or the externally supplied data-ready signal. Software uses a simple byte-wide register port. A write is one cycle with `regWrEn` high. A read is combinational on `regAddr`, and it counts as an access in a cycle where `regRdEn` is high.

Top module: `wake_thresh_irq`

## Requirements
- R1: The configuration register at address 0 is read/write and resets to 0. Its bit fields are:
  - bit 0: X low enable
  - bit 1: X high enable
  - bit 2: Y low enable
  - bit 3: Y high enable
  - bit 4: Z low enable
  - bit 5: Z high enable
  - bit 6: latch mode
  - bit 7: route the interrupt to the pin
- R2: On a sample-valid cycle, an axis whose high enable is set gets its high flag set when the signed sample is strictly greater than the signed threshold. A sample equal to the threshold does not set the flag.
- R3: On a sample-valid cycle, an axis whose low enable is set gets its low flag set when the signed sample is strictly less than the signed threshold. A sample equal to the threshold does not set the flag.
- R4: A condition whose enable bit is clear has no effect: its flag is not set, whatever the sample.
- R5: The threshold is written and read back as two bytes. The low byte is at address 3 and the high byte is at address 4. Both reset to 0.
- R6: The source register at address 1 is read-only. Bits 5..0 hold the flags, in the same positions as the enables in R1. Bit 6 is the interrupt-active bit, the OR of the flags. Bit 7 reads 0. Writes to this address are ignored.
- R7: With latch mode clear, each sample-valid cycle replaces the flags with the result of that sample. Changes on the sample inputs without the strobe do not alter the flags.
- R8: With latch mode set, the flags from each new sample are ORed into the held flags. The flags then stay set until the next acknowledge read.
- R9: A read at address 2 returns the source value and clears all flags at the end of that cycle.
- R10: If an acknowledge read and a sample-valid cycle coincide, the flags are loaded with the new sample's result. A firing sample is therefore never lost.
- R11: With configuration bit 7 set, `irqPin` shows the interrupt-active bit. With bit 7 clear, `irqPin` equals `dataReady`.
- R12: After reset all flags are 0, the threshold is 0 and `irqPin` follows `dataReady`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (needed for the acknowledge side effect) |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational on regAddr |
| sampleValid | input | 1 | New sample set present on the sample inputs |
| sampleX | input | 16 | Signed X axis sample |
| sampleY | input | 16 | Signed Y axis sample |
| sampleZ | input | 16 | Signed Z axis sample |
| dataReady | input | 1 | Data-ready signal passed to the pin when the interrupt is not routed |
| irqPin | output | 1 | Shared pin: interrupt request or data-ready |

## Verification
The assertions assume that the sample inputs are stable and free of X in every cycle where `sampleValid` is high. They also assume that `regRdEn` at the acknowledge address is a single-cycle pulse per intended acknowledge. The stimulus drives every input on the falling clock edge. It holds the sample strobe and the read strobe for exactly one rising edge each. Samples near the extremes of the signed range are saturated in the bench before being driven, so no wrapped value ever reaches the comparators.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int REG_W    = 8;
  localparam int SAMPLE_W = 2 * REG_W;
  localparam int AXES     = 3;
  localparam int EN_W     = 2 * AXES;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_CFG    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SRC    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ACK    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_THR_LO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_THR_HI = 3'd4;

  localparam int LATCH_BIT = EN_W;
  localparam int ROUTE_BIT = EN_W + 1;

  typedef struct packed {
    logic wrCfg;
    logic wrThrLo;
    logic wrThrHi;
    logic ackRd;
    logic sampleStb;
  } strobe_t;

  typedef enum logic [2:0] {
    SEL_CFG,
    SEL_SRC,
    SEL_THR_LO,
    SEL_THR_HI,
    SEL_NONE
  } reg_sel_t;
endpackage

// File: rtl/wake_axis_cmp.sv
module wake_axis_cmp #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] sample,
  input  logic signed [W-1:0] thr,
  output logic                isHigh,
  output logic                isLow
);
  always_comb begin
    isHigh = (sample > thr);
    isLow  = (sample < thr);
  end
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              sampleValid,
  output strobe_t           stb,
  output reg_sel_t          regSel
);
  always_comb begin
    stb           = '0;
    stb.sampleStb = sampleValid;
    if (regWrEn) begin
      stb.wrCfg   = (regAddr == ADDR_CFG);
      stb.wrThrLo = (regAddr == ADDR_THR_LO);
      stb.wrThrHi = (regAddr == ADDR_THR_HI);
    end
    stb.ackRd = regRdEn && (regAddr == ADDR_ACK);
  end

  always_comb begin
    case (regAddr)
      ADDR_CFG:    regSel = SEL_CFG;
      ADDR_SRC,
      ADDR_ACK:    regSel = SEL_SRC;
      ADDR_THR_LO: regSel = SEL_THR_LO;
      ADDR_THR_HI: regSel = SEL_THR_HI;
      default:     regSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  reg_sel_t                   regSel,
  input  logic [REG_W-1:0]           regWrData,
  input  logic signed [SAMPLE_W-1:0] sampleX,
  input  logic signed [SAMPLE_W-1:0] sampleY,
  input  logic signed [SAMPLE_W-1:0] sampleZ,
  input  logic                       dataReady,
  output logic [REG_W-1:0]           regRdData,
  output logic                       irqPin
);
  logic [REG_W-1:0]           cfgReg;
  logic signed [SAMPLE_W-1:0] thrReg;
  logic [EN_W-1:0]            srcFlags;
  logic [EN_W-1:0]            rawFlags;
  logic [EN_W-1:0]            newFlags;
  logic [AXES-1:0]            hiHit;
  logic [AXES-1:0]            loHit;
  logic signed [SAMPLE_W-1:0] smp [AXES];
  logic                       active;

  assign smp[0] = sampleX;
  assign smp[1] = sampleY;
  assign smp[2] = sampleZ;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    wake_axis_cmp #(.W(SAMPLE_W)) u_cmp (
      .sample(smp[a]),
      .thr   (thrReg),
      .isHigh(hiHit[a]),
      .isLow (loHit[a])
    );
    assign rawFlags[2*a]   = loHit[a];
    assign rawFlags[2*a+1] = hiHit[a];

    // R2 R3: a sample can never be both above and below the threshold
    a_r2_r3_exclusive: assert property (@(posedge clk) disable iff (!rstN)
      stb.sampleStb |-> $onehot0({hiHit[a], loHit[a]}));
  end

  assign newFlags = rawFlags & cfgReg[EN_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
      thrReg <= '0;
    end else begin
      if (stb.wrCfg)   cfgReg                   <= regWrData;
      if (stb.wrThrLo) thrReg[REG_W-1:0]        <= regWrData;
      if (stb.wrThrHi) thrReg[SAMPLE_W-1:REG_W] <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcFlags <= '0;
    end else if (stb.sampleStb) begin
      if (cfgReg[LATCH_BIT] && !stb.ackRd) srcFlags <= srcFlags | newFlags;
      else                                 srcFlags <= newFlags;
    end else if (stb.ackRd) begin
      srcFlags <= '0;
    end
  end

  assign active = |srcFlags;
  assign irqPin = cfgReg[ROUTE_BIT] ? active : dataReady;

  always_comb begin
    case (regSel)
      SEL_CFG:    regRdData = cfgReg;
      SEL_SRC:    regRdData = {{(REG_W-EN_W-1){1'b0}}, active, srcFlags};
      SEL_THR_LO: regRdData = thrReg[REG_W-1:0];
      SEL_THR_HI: regRdData = thrReg[SAMPLE_W-1:REG_W];
      default:    regRdData = '0;
    endcase
  end

  // R10: a firing sample always leaves at least one flag set
  a_r10_no_lost_event: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sampleStb && (newFlags != '0)) |=> (srcFlags != '0));

  // R8: in latch mode, held flags never drop without an acknowledge
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg[LATCH_BIT] && !stb.ackRd) |=> ((srcFlags & $past(srcFlags)) == $past(srcFlags)));

  // R9: an acknowledge with no sample empties the source
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackRd && !stb.sampleStb) |=> (srcFlags == '0));

  // R4: a newly raised flag must belong to an enabled condition
  a_r4_only_enabled: assert property (@(posedge clk) disable iff (!rstN)
    stb.sampleStb |=> ((srcFlags & ~$past(srcFlags) & ~$past(cfgReg[EN_W-1:0])) == '0));

  // R7: without a strobe or an acknowledge the flags stay put
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.sampleStb && !stb.ackRd) |=> $stable(srcFlags));
endmodule

// File: rtl/wake_thresh_irq.sv
module wake_thresh_irq
  import wake_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic                       regRdEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [REG_W-1:0]           regWrData,
  output logic [REG_W-1:0]           regRdData,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleX,
  input  logic signed [SAMPLE_W-1:0] sampleY,
  input  logic signed [SAMPLE_W-1:0] sampleZ,
  input  logic                       dataReady,
  output logic                       irqPin
);
  strobe_t  stb;
  reg_sel_t regSel;

  wake_ctrl u_ctrl (
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .sampleValid(sampleValid),
    .stb        (stb),
    .regSel     (regSel)
  );

  wake_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regSel   (regSel),
    .regWrData(regWrData),
    .sampleX  (sampleX),
    .sampleY  (sampleY),
    .sampleZ  (sampleZ),
    .dataReady(dataReady),
    .regRdData(regRdData),
    .irqPin   (irqPin)
  );
endmodule

// File: tb/test_wake_thresh_irq.sv
module test_wake_thresh_irq;
  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               regWrEn = 1'b0;
  logic               regRdEn = 1'b0;
  logic [2:0]         regAddr = '0;
  logic [7:0]         regWrData = '0;
  logic [7:0]         regRdData;
  logic               sampleValid = 1'b0;
  logic signed [15:0] sampleX = '0;
  logic signed [15:0] sampleY = '0;
  logic signed [15:0] sampleZ = '0;
  logic               dataReady = 1'b0;
  logic               irqPin;

  int total = 0;
  int bad = 0;

  wake_thresh_irq i_wake_thresh_irq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sampleValid(sampleValid), .sampleX(sampleX), .sampleY(sampleY),
    .sampleZ(sampleZ), .dataReady(dataReady), .irqPin(irqPin)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic smp(input int x, input int y, input int z, input bit withAck);
    @(negedge clk);
    sampleX = 16'(x); sampleY = 16'(y); sampleZ = 16'(z);
    sampleValid = 1'b1;
    if (withAck) begin regAddr = 3'd2; regRdEn = 1'b1; end
    @(negedge clk);
    sampleValid = 1'b0; regRdEn = 1'b0;
  endtask

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int flagsOf(input int x, input int y, input int z, input int t, input int en);
    int f;
    f = 0;
    if (x < t) f |= 1;
    if (x > t) f |= 2;
    if (y < t) f |= 4;
    if (y > t) f |= 8;
    if (z < t) f |= 16;
    if (z > t) f |= 32;
    return f & en;
  endfunction

  function automatic int srcOf(input int f);
    return f | ((f != 0) ? 64 : 0);
  endfunction

  task automatic setThr(input int t);
    logic [15:0] tv;
    tv = 16'(t);
    wr(3'd3, tv[7:0]);
    wr(3'd4, tv[15:8]);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int thrList [6];
    int x, y, z, e;
    thrList = '{-32768, -1, 0, 1, 300, 32767};

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state
    rd(3'd0, d); check("R12 cfg reset", d, 0);
    rd(3'd1, d); check("R12 src reset", d, 0);
    rd(3'd3, d); check("R12 thr lo reset", d, 0);
    rd(3'd4, d); check("R12 thr hi reset", d, 0);
    dataReady = 1'b1; #1 check("R12 pin follows dataReady hi", irqPin, 1);
    dataReady = 1'b0; #1 check("R12 pin follows dataReady lo", irqPin, 0);

    // R1 config readback
    wr(3'd0, 8'hA5); rd(3'd0, d); check("R1 cfg readback", d, 8'hA5);
    wr(3'd0, 8'h3F); rd(3'd0, d); check("R1 cfg readback", d, 8'h3F);

    // R5 threshold bytes
    setThr(16'h8A5C);
    rd(3'd3, d); check("R5 thr lo", d, 8'h5C);
    rd(3'd4, d); check("R5 thr hi", d, 8'h8A);

    // R6 writes to source ignored
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R6 src write ignored", d, 0);

    // R2 R3 R6 R7 sweep: non-latched, all enabled
    wr(3'd0, 8'h3F);
    foreach (thrList[i]) begin
      setThr(thrList[i]);
      for (int dx = -1; dx <= 1; dx++)
        for (int dy = -1; dy <= 1; dy++)
          for (int dz = -1; dz <= 1; dz++) begin
            x = sat(thrList[i] + dx);
            y = sat(thrList[i] + dy);
            z = sat(thrList[i] + dz);
            smp(x, y, z, 1'b0);
            rd(3'd1, d);
            check("R2 R3 R7 sweep src", d, srcOf(flagsOf(x, y, z, thrList[i], 63)));
          end
    end

    // R7 no strobe: inputs change, flags unchanged
    setThr(0);
    smp(5, -5, 5, 1'b0);
    @(negedge clk); sampleX = -16'sd9; sampleY = 16'sd9; sampleZ = -16'sd9;
    repeat (2) @(negedge clk);
    rd(3'd1, d); check("R7 no strobe ignored", d, srcOf(flagsOf(5, -5, 5, 0, 63)));
    smp(0, 0, 0, 1'b0);
    rd(3'd1, d); check("R7 recompute to zero", d, 0);

    // R4 all enable masks
    for (int m = 0; m < 64; m++) begin
      wr(3'd0, 8'(m));
      smp(100, -100, 100, 1'b0);
      rd(3'd1, d); check("R4 mask pattern A", d, srcOf(flagsOf(100, -100, 100, 0, m)));
      smp(-100, 100, -100, 1'b0);
      rd(3'd1, d); check("R4 mask pattern B", d, srcOf(flagsOf(-100, 100, -100, 0, m)));
    end

    // R8 latched accumulate
    wr(3'd0, 8'h7F);
    rd(3'd2, d);
    smp(50, 0, 0, 1'b0);
    smp(0, -50, 0, 1'b0);
    rd(3'd1, d); check("R8 latched OR", d, srcOf(2 | 4));
    smp(0, 0, 0, 1'b0);
    rd(3'd1, d); check("R8 held on quiet sample", d, srcOf(2 | 4));

    // R9 ack returns then clears
    rd(3'd2, d); check("R9 ack returns source", d, srcOf(2 | 4));
    rd(3'd1, d); check("R9 cleared after ack", d, 0);

    // R9 ack in non-latched mode
    wr(3'd0, 8'h3F);
    smp(0, 0, -7, 1'b0);
    rd(3'd2, d); check("R9 ack nonlatched returns", d, srcOf(16));
    rd(3'd1, d); check("R9 ack nonlatched clears", d, 0);

    // R10 simultaneous ack and firing sample
    wr(3'd0, 8'h7F);
    smp(50, 0, 0, 1'b0);
    smp(0, 0, 50, 1'b1);
    rd(3'd1, d); check("R10 new firing kept", d, srcOf(32));
    smp(0, 0, 0, 1'b1);
    rd(3'd1, d); check("R10 quiet sample with ack", d, 0);

    // R11 pin routing
    wr(3'd0, 8'hFF);
    smp(0, 9, 0, 1'b0);
    dataReady = 1'b0; #1 check("R11 pin shows irq", irqPin, 1);
    rd(3'd2, d);
    dataReady = 1'b1; #1 check("R11 pin irq cleared", irqPin, 0);
    wr(3'd0, 8'h7F);
    smp(0, 9, 0, 1'b0);
    dataReady = 1'b0; #1 check("R11 pin shows dataReady", irqPin, 0);
    dataReady = 1'b1; #1 check("R11 pin shows dataReady hi", irqPin, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule